// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block times one fan tachometer input. The pin passes through a synchroniser and a debounce filter whose required stable length is chosen by a two-bit code. The filtered level feeds an edge detector, and a two-bit mode picks which transitions bound a measurement. A prescaler divides the core clock by a power of four and drives a saturating tick counter. At each qualifying edge the counter value is latched, and the counter then starts again.

The latched count is published with two flags. A one-cycle update strobe marks each new value. A full flag shows that at least one complete edge-to-edge interval has been latched since the block was enabled. Each new value is compared against a programmable threshold, in a direction the user selects. When the comparison hits and interrupts are enabled, a sticky interrupt flag sets. Software clears that flag with a one-cycle clear pulse. The RPM conversion, the register bus and any channel muxing belong to the logic around this block.

Top module: `fan_tach_meter`

## Requirements
- R1: `sts_raw` shows the level of `tach_in` delayed by the synchroniser (two clocks at the default depth).
- R2: Debounce code 00 requires 3 consecutive clocks at a new synchronised level before `sts_filtered` follows. Code 01 requires 2 and code 10 requires 1. A shorter pulse is discarded.
- R3: Debounce code 11 bypasses the filter, so `sts_filtered` equals `sts_raw` and single-clock glitches count as edges.
- R4: Edge mode 00 measures from falling edge to falling edge. Mode 01 measures from rising edge to rising edge. Modes 10 and 11 end a measurement on every transition of the filtered level.
- R5: The tick rate is the clock divided by 4^n, where n is `cfg_div_exp`. Values above 11 are treated as 11.
- R6: A latched value equals the number of ticks that occurred after the previous qualifying edge, up to and including the capturing clock. The first qualifying edge after enable only arms the counter.
- R7: `sts_update` pulses for one clock with each new `sts_value`. `sts_full` sets with the first latched value and stays set while enabled.
- R8: If no qualifying edge arrives, the counter stops at all-ones. Reaching all-ones latches that value once, with an update pulse, so a stalled fan reads as the maximum.
- R9: While `cfg_irq_en` is 1, an update whose value is above `cfg_threshold` sets `sts_irq` on the next clock. This applies when `cfg_limit_below` is 0. When `cfg_limit_below` is 1, a value below the threshold sets the flag instead.
- R10: `sts_irq` holds until `irq_clear` is 1 for a clock. A new setting event in the same clock wins over the clear.
- R11: While `cfg_enable` is 0, the counter, prescaler, `sts_value`, `sts_update` and `sts_full` are held at zero. `sts_irq` is left unchanged.
- R12: After `rst`, all status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_in | input | 1 | Asynchronous tachometer pin |
| cfg_enable | input | 1 | Measurement enable |
| cfg_irq_en | input | 1 | Allows the threshold hit to set the interrupt flag |
| cfg_limit_below | input | 1 | 0: trigger above threshold, 1: trigger below |
| cfg_debounce | input | 2 | Debounce length code (00=3, 01=2, 10=1, 11=off) |
| cfg_edge_mode | input | 2 | 00 falling, 01 rising, 10/11 both edges |
| cfg_div_exp | input | DIV_W | Prescaler exponent n, tick = clk / 4^n |
| cfg_threshold | input | COUNT_W | Interrupt comparison limit |
| irq_clear | input | 1 | One-clock clear of the interrupt flag |
| sts_raw | output | 1 | Synchronised pin level |
| sts_filtered | output | 1 | Debounced pin level |
| sts_value | output | COUNT_W | Latched tick count |
| sts_update | output | 1 | One-clock strobe on a new value |
| sts_full | output | 1 | A complete measurement has been latched |
| sts_irq | output | 1 | Sticky threshold interrupt flag |

## Verification
Square and asymmetric waves of known period are applied in every edge mode. The asymmetric duty is what separates rising, falling and both-edge timing, because only the both-edge mode returns the high time. Glitches shorter than the debounce length must leave the period intact. The same glitch with the filter bypassed must split the period, which shows that the filter and not the edge logic rejects it. Divider settings 1 and 2 confirm exact tick counts per period. A held-low pin drives the counter into saturation. Threshold runs in both directions and with the interrupt enable off separate the compare from its gating.

// File: rtl/tach_pkg.sv
package tach_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL     = 2'b00,
    EDGE_RISE     = 2'b01,
    EDGE_BOTH     = 2'b10,
    EDGE_BOTH_ALT = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    DEB_THREE = 2'b00,
    DEB_TWO   = 2'b01,
    DEB_ONE   = 2'b10,
    DEB_OFF   = 2'b11
  } deb_code_e;

  // Number of consecutive stable clocks a debounce code asks for
  function automatic int deb_length(input logic [1:0] code);
    return 3 - int'(code);
  endfunction

endpackage

// File: rtl/tach_input_filter.sv
module tach_input_filter
  import tach_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] deb_code,
  output logic       raw_lvl,
  output logic       clean_lvl
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   stable_q;
  logic [1:0]             run_q;
  logic                   bypass;

  generate
    if (SYNC_STAGES == 1) begin : g_one_stage
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  assign raw_lvl = sync_q[SYNC_STAGES-1];
  assign bypass  = (deb_code == DEB_OFF);

  // A new level must persist for deb_length() clocks before it is accepted
  always_ff @(posedge clk) begin
    if (rst) begin
      stable_q <= 1'b0;
      run_q    <= 2'd0;
    end else if (bypass || raw_lvl == stable_q) begin
      stable_q <= raw_lvl;
      run_q    <= 2'd0;
    end else if (int'(run_q) == deb_length(deb_code) - 1) begin
      stable_q <= raw_lvl;
      run_q    <= 2'd0;
    end else begin
      run_q    <= run_q + 2'd1;
    end
  end

  assign clean_lvl = bypass ? raw_lvl : stable_q;

endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 11,
  localparam int PRE_W  = 2 * MAX_EXP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;
  int               eff_exp;

  always_comb begin
    eff_exp = (int'(exp_sel) > MAX_EXP) ? MAX_EXP : int'(exp_sel);
    limit   = PRE_W'((64'(1) << (2 * eff_exp)) - 64'(1));
  end

  assign tick = run && (pre_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run)        pre_q <= '0;
    else if (pre_q >= limit) pre_q <= '0;
    else                    pre_q <= pre_q + PRE_W'(1);
  end

endmodule

// File: rtl/tach_period_counter.sv
module tach_period_counter
  import tach_pkg::*;
#(
  parameter int COUNT_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               lvl,
  input  logic [1:0]         edge_mode,
  input  logic               tick,
  output logic [COUNT_W-1:0] value,
  output logic               update,
  output logic               full
);

  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  logic               lvl_d_q;
  logic               rise, fall, hit;
  logic [COUNT_W-1:0] cnt_q, cnt_inc;
  logic               armed_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_d_q <= 1'b0;
    else     lvl_d_q <= lvl;
  end

  assign rise = lvl & ~lvl_d_q;
  assign fall = ~lvl & lvl_d_q;

  always_comb begin
    unique case (edge_mode)
      EDGE_FALL: hit = fall;
      EDGE_RISE: hit = rise;
      default:   hit = rise | fall;
    endcase
  end

  assign cnt_inc = (tick && cnt_q != CNT_MAX) ? cnt_q + COUNT_W'(1) : cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      value   <= '0;
      update  <= 1'b0;
      full    <= 1'b0;
    end else begin
      update <= 1'b0;
      if (hit) begin
        if (armed_q) begin
          value  <= cnt_inc;
          update <= 1'b1;
          full   <= 1'b1;
        end
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (armed_q) begin
        cnt_q <= cnt_inc;
        if (cnt_inc == CNT_MAX && cnt_q != CNT_MAX) begin
          value  <= CNT_MAX;
          update <= 1'b1;
          full   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import tach_pkg::*;
#(
  parameter int COUNT_W     = 20,
  parameter int DIV_W       = 4,
  parameter int MAX_DIV_EXP = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tach_in,
  input  logic               cfg_enable,
  input  logic               cfg_irq_en,
  input  logic               cfg_limit_below,
  input  logic [1:0]         cfg_debounce,
  input  logic [1:0]         cfg_edge_mode,
  input  logic [DIV_W-1:0]   cfg_div_exp,
  input  logic [COUNT_W-1:0] cfg_threshold,
  input  logic               irq_clear,
  output logic               sts_raw,
  output logic               sts_filtered,
  output logic [COUNT_W-1:0] sts_value,
  output logic               sts_update,
  output logic               sts_full,
  output logic               sts_irq
);

  logic tick;
  logic beyond;
  logic irq_q;

  tach_input_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
    .clk       (clk),
    .rst       (rst),
    .pin       (tach_in),
    .deb_code  (cfg_debounce),
    .raw_lvl   (sts_raw),
    .clean_lvl (sts_filtered)
  );

  tach_prescaler #(.EXP_W(DIV_W), .MAX_EXP(MAX_DIV_EXP)) u_prescaler (
    .clk     (clk),
    .rst     (rst),
    .run     (cfg_enable),
    .exp_sel (cfg_div_exp),
    .tick    (tick)
  );

  tach_period_counter #(.COUNT_W(COUNT_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .run       (cfg_enable),
    .lvl       (sts_filtered),
    .edge_mode (cfg_edge_mode),
    .tick      (tick),
    .value     (sts_value),
    .update    (sts_update),
    .full      (sts_full)
  );

  assign beyond = cfg_limit_below ? (sts_value < cfg_threshold)
                                  : (sts_value > cfg_threshold);

  always_ff @(posedge clk) begin
    if (rst)                                   irq_q <= 1'b0;
    else if (sts_update && cfg_irq_en && beyond) irq_q <= 1'b1;
    else if (irq_clear)                        irq_q <= 1'b0;
  end

  assign sts_irq = irq_q;

endmodule

// File: rtl/fan_tach_meter_checker.sv
module fan_tach_meter_checker #(
  parameter int COUNT_W     = 20,
  parameter int SYNC_STAGES = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               tach_in,
  input logic               cfg_enable,
  input logic               cfg_irq_en,
  input logic               irq_clear,
  input logic               sts_raw,
  input logic [COUNT_W-1:0] sts_value,
  input logic               sts_update,
  input logic               sts_full,
  input logic               sts_irq
);

  int unsigned since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 0;
    else if (since_rst < SYNC_STAGES) since_rst <= since_rst + 1;
  end

  assert_raw_follow_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= SYNC_STAGES) |-> (sts_raw == $past(tach_in, SYNC_STAGES)));

  assert_value_hold_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_enable |=> (sts_update || $stable(sts_value)));

  assert_update_full_R7: assert property (@(posedge clk) disable iff (rst)
    sts_update |-> sts_full);

  assert_full_held_R7: assert property (@(posedge clk) disable iff (rst)
    (sts_full && cfg_enable) |=> sts_full);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_irq) |-> $past(sts_update && cfg_irq_en));

  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (sts_irq && !irq_clear) |=> sts_irq);

  assert_disable_clear_R11: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> (!sts_full && !sts_update && sts_value == '0));

endmodule

bind fan_tach_meter fan_tach_meter_checker #(
  .COUNT_W     (COUNT_W),
  .SYNC_STAGES (SYNC_STAGES)
) u_fan_tach_meter_checker (
  .clk        (clk),
  .rst        (rst),
  .tach_in    (tach_in),
  .cfg_enable (cfg_enable),
  .cfg_irq_en (cfg_irq_en),
  .irq_clear  (irq_clear),
  .sts_raw    (sts_raw),
  .sts_value  (sts_value),
  .sts_update (sts_update),
  .sts_full   (sts_full),
  .sts_irq    (sts_irq)
);

// File: tb/test_fan_tach_meter.sv
module test_fan_tach_meter;

  localparam int CW  = 12;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tach_in = 1'b0;
  logic          cfg_enable = 1'b0;
  logic          cfg_irq_en = 1'b0;
  logic          cfg_limit_below = 1'b0;
  logic [1:0]    cfg_debounce = 2'b00;
  logic [1:0]    cfg_edge_mode = 2'b00;
  logic [3:0]    cfg_div_exp = 4'd0;
  logic [CW-1:0] cfg_threshold = '1;
  logic          irq_clear = 1'b0;
  logic          sts_raw, sts_filtered, sts_update, sts_full, sts_irq;
  logic [CW-1:0] sts_value;

  int checks = 0;
  int fails  = 0;
  int last_val = -1;
  bit done = 0;

  always #2 clk = ~clk;

  fan_tach_meter #(.COUNT_W(CW)) i_fan_tach_meter (
    .clk(clk), .rst(rst), .tach_in(tach_in), .cfg_enable(cfg_enable),
    .cfg_irq_en(cfg_irq_en), .cfg_limit_below(cfg_limit_below),
    .cfg_debounce(cfg_debounce), .cfg_edge_mode(cfg_edge_mode),
    .cfg_div_exp(cfg_div_exp), .cfg_threshold(cfg_threshold),
    .irq_clear(irq_clear), .sts_raw(sts_raw), .sts_filtered(sts_filtered),
    .sts_value(sts_value), .sts_update(sts_update), .sts_full(sts_full),
    .sts_irq(sts_irq)
  );

  // Behavioural reference, advanced once per rising edge
  bit m_s1, m_s2, m_filt, m_prev, m_armed, m_upd, m_full, m_irq;
  int m_run, m_pre, m_cnt, m_val;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_filt = 0; m_prev = 0; m_armed = 0;
      m_upd = 0; m_full = 0; m_irq = 0; m_run = 0; m_pre = 0;
      m_cnt = 0; m_val = 0;
    end else begin
      bit clean, hit, tick, n_filt, n_irq, n_upd, n_full, n_armed;
      int n_run, eff, lim, inc, n_cnt, n_val;
      clean = (cfg_debounce == 2'b11) ? m_s2 : m_filt;
      if (cfg_debounce == 2'b11 || m_s2 == m_filt) begin
        n_filt = m_s2; n_run = 0;
      end else if (m_run + 1 >= 3 - int'(cfg_debounce)) begin
        n_filt = m_s2; n_run = 0;
      end else begin
        n_filt = m_filt; n_run = m_run + 1;
      end
      case (cfg_edge_mode)
        2'b00:   hit = !clean && m_prev;
        2'b01:   hit = clean && !m_prev;
        default: hit = clean != m_prev;
      endcase
      eff  = (cfg_div_exp > 11) ? 11 : int'(cfg_div_exp);
      lim  = (1 << (2 * eff)) - 1;
      tick = cfg_enable && m_pre >= lim;
      n_irq = m_irq;
      if (m_upd && cfg_irq_en &&
          (cfg_limit_below ? (m_val < int'(cfg_threshold)) : (m_val > int'(cfg_threshold))))
        n_irq = 1;
      else if (irq_clear)
        n_irq = 0;
      inc = (tick && m_cnt < MAXV) ? m_cnt + 1 : m_cnt;
      n_cnt = m_cnt; n_val = m_val; n_upd = 0; n_full = m_full; n_armed = m_armed;
      if (!cfg_enable) begin
        n_cnt = 0; n_val = 0; n_full = 0; n_armed = 0;
      end else if (hit) begin
        if (m_armed) begin n_val = inc; n_upd = 1; n_full = 1; end
        n_cnt = 0; n_armed = 1;
      end else if (m_armed) begin
        if (inc == MAXV && m_cnt != MAXV) begin n_val = MAXV; n_upd = 1; n_full = 1; end
        n_cnt = inc;
      end
      m_pre  = !cfg_enable ? 0 : (m_pre >= lim ? 0 : m_pre + 1);
      m_prev = clean;
      m_filt = n_filt; m_run = n_run;
      m_s2 = m_s1; m_s1 = tach_in;
      m_cnt = n_cnt; m_val = n_val; m_upd = n_upd; m_full = n_full;
      m_armed = n_armed; m_irq = n_irq;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk("R1 sts_raw", int'(sts_raw), int'(m_s2));
      chk("R2 sts_filtered", int'(sts_filtered),
          int'((cfg_debounce == 2'b11) ? m_s2 : m_filt));
      chk("R6 sts_value", int'(sts_value), m_val);
      chk("R7 sts_update", int'(sts_update), int'(m_upd));
      chk("R7 sts_full", int'(sts_full), int'(m_full));
      chk("R9 sts_irq", int'(sts_irq), int'(m_irq));
      if (sts_update) last_val = int'(sts_value);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wave(input int hi, input int lo, input int periods, input int glitch);
    for (int p = 0; p < periods; p++) begin
      for (int i = 0; i < hi; i++) begin
        @(negedge clk);
        tach_in = (glitch > 0 && i >= hi / 2 && i < hi / 2 + glitch) ? 1'b0 : 1'b1;
      end
      for (int i = 0; i < lo; i++) begin
        @(negedge clk);
        tach_in = 1'b0;
      end
    end
    idle(8);
  endtask

  task automatic pulse_clear();
    @(negedge clk); irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(5);
    // R12: reset state
    chk("R12 value after reset", int'(sts_value), 0);
    chk("R12 full after reset", int'(sts_full), 0);
    chk("R12 irq after reset", int'(sts_irq), 0);
    rst = 1'b0;
    cfg_enable = 1'b1; cfg_irq_en = 1'b1; cfg_threshold = CW'(4000);
    idle(4);

    // R6/R7: square wave, period 40, divider 0
    wave(20, 20, 6, 0);
    chk("R6 period 40 div0", last_val, 40);
    chk("R7 full after measurement", int'(sts_full), 1);

    // R2: 2-clock glitch rejected by 3-clock debounce
    wave(20, 20, 4, 2);
    chk("R2 glitch rejected code 00", last_val, 40);
    cfg_debounce = 2'b01;
    wave(20, 20, 4, 1);
    chk("R2 glitch rejected code 01", last_val, 40);

    // R3: bypass lets the glitch split the period
    cfg_debounce = 2'b11;
    wave(20, 20, 4, 1);
    chk("R3 bypass glitch counted", last_val, 10);
    cfg_debounce = 2'b00;

    // R4: edge modes with asymmetric duty
    cfg_edge_mode = 2'b01;
    wave(10, 30, 4, 0);
    chk("R4 rising mode", last_val, 40);
    cfg_edge_mode = 2'b10;
    wave(10, 30, 4, 0);
    chk("R4 both-edge mode", last_val, 10);
    cfg_edge_mode = 2'b11;
    wave(10, 30, 4, 0);
    chk("R4 mode 11 as both", last_val, 10);
    cfg_edge_mode = 2'b00;

    // R5: prescaler
    cfg_div_exp = 4'd1;
    wave(20, 20, 4, 0);
    chk("R5 div exponent 1", last_val, 10);
    cfg_div_exp = 4'd2;
    wave(32, 32, 4, 0);
    chk("R5 div exponent 2", last_val, 4);
    cfg_div_exp = 4'd0;

    // R9/R10: threshold interrupt
    cfg_threshold = CW'(50); cfg_limit_below = 1'b0;
    wave(30, 30, 3, 0);
    chk("R9 above threshold sets irq", int'(sts_irq), 1);
    idle(10);
    chk("R10 irq held", int'(sts_irq), 1);
    pulse_clear();
    chk("R10 irq cleared", int'(sts_irq), 0);
    cfg_limit_below = 1'b1;
    wave(20, 20, 3, 0);
    chk("R9 below threshold sets irq", int'(sts_irq), 1);
    pulse_clear();
    cfg_irq_en = 1'b0;
    wave(20, 20, 3, 0);
    chk("R9 irq gated by enable", int'(sts_irq), 0);

    // R8: stalled input saturates
    cfg_irq_en = 1'b1; cfg_limit_below = 1'b0;
    wave(20, 20, 1, 0);
    idle(4300);
    chk("R8 saturated value", last_val, MAXV);
    chk("R8 irq on saturation", int'(sts_irq), 1);

    // R11: disable clears counter state, not the irq flag
    @(negedge clk); cfg_enable = 1'b0;
    idle(3);
    chk("R11 value cleared", int'(sts_value), 0);
    chk("R11 full cleared", int'(sts_full), 0);
    chk("R11 irq kept", int'(sts_irq), 1);
    cfg_enable = 1'b1;
    wave(20, 20, 1, 0);
    chk("R6 first edge only arms", int'(sts_full), 0);
    wave(20, 20, 2, 0);
    chk("R6 measurement after re-arm", last_val, 40);

    idle(5);
    finish_run();
  end

endmodule